// File: doc/BRIEF.md
# Fractional Ratio Pulse Generator

This block derives a slower event stream from a source clock. The stream's long-term rate is the source frequency multiplied by a numerator n and divided by a denominator m. Both values arrive packed in one 32-bit configuration word. An accumulator adds n on every source cycle. Each time the sum reaches m, the block subtracts m and issues a one-cycle enable pulse. A second output toggles on every pulse, which gives a clock-like square wave at half the pulse rate. Individual pulse spacing varies by up to one source cycle. Only the average over a denominator-length window is exact.

The configuration word is sampled on every clock edge. The block takes a word into its held ratio only when two conditions are met: both fields are non-zero, and the word differs from the ratio already held. Taking a word restarts the accumulator and the toggle output from zero. A held ratio with n greater than m is kept but treated as invalid, and no pulses are issued while it is held. Any integer predivider ahead of this block is expected to be set to divide-by-1. The best n/m pair is computed outside the block.

Top module: `frac_rate_gen`

## Requirements
- R1: After reset the held ratio is zero, and `tick_o` and `div_clk_o` stay 0 until a configuration word is taken.
- R2: The numerator n is taken from `cfg_word[31:16]` and the denominator m from `cfg_word[15:0]`, each an unsigned 16-bit value up to 65535.
- R3: A word with n = 0 or m = 0 is ignored: the held ratio and the accumulator phase continue unchanged.
- R4: A taken word with n > m is held as invalid; `tick_o` stays 0 and `div_clk_o` holds its value while it is held.
- R5: A word with both fields non-zero that differs from the held ratio is taken at the next clock edge. That edge clears the accumulator and `div_clk_o`, so the first pulse comes ceil(m/n) cycles after the taking edge, counting that edge's cycle as the first.
- R6: While a valid ratio is held, every run of m consecutive cycles contains exactly n cycles with `tick_o` = 1.
- R7: When n = m, `tick_o` is 1 in every cycle.
- R8: `div_clk_o` inverts at the clock edge ending each cycle in which `tick_o` is 1, and keeps its value otherwise (a taking edge overrides this and clears it).
- R9: Presenting the word already held again does not restart the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Numerator in bits 31:16, denominator in bits 15:0 |
| tick_o | output | 1 | One-cycle enable, average rate f·n/m |
| div_clk_o | output | 1 | Toggles on every enable pulse |

## Verification
The ratio is tried at several extremes: 1/1 and 65535/65535 (pulse every cycle), 3/7 and 5/16 (irregular spacing), 1/300 (sparse, long gaps), and 255/256 and 1000/1024 (dense, with rare gaps). Together these separate a correct compare-and-subtract from an off-by-one threshold or a missed carry. Each denominator-length window is counted separately, and a cycle-exact reference model is compared on every cycle. This shows that both the total and the phase after each taking edge are correct. Zero-field words, an n > m word and a repeated identical word are placed between runs to show which words restart the phase and which leave it alone.

// File: rtl/frac_rate_gen.sv
module frac_rate_gen #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*FW-1:0] cfg_word,
  output logic          tick_o,
  output logic          div_clk_o
);
  localparam int AW = FW + 1;

  logic [FW-1:0] num_q, den_q;
  logic [AW-1:0] acc_q;

  wire [FW-1:0] num_in = cfg_word[2*FW-1:FW];
  wire [FW-1:0] den_in = cfg_word[FW-1:0];

  // R2, R3, R9: load only non-zero fields that change the ratio
  wire take   = (num_in != '0) && (den_in != '0) && ({num_in, den_in} != {num_q, den_q});
  wire cfg_ok = (den_q != '0) && (num_q <= den_q);

  wire [AW-1:0] sum = acc_q + AW'(num_q);

  assign tick_o = cfg_ok && (sum >= AW'(den_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q     <= '0;
      den_q     <= '0;
      acc_q     <= '0;
      div_clk_o <= 1'b0;
    end else if (take) begin
      num_q     <= num_in;
      den_q     <= den_in;
      acc_q     <= '0;
      div_clk_o <= 1'b0;
    end else if (cfg_ok) begin
      acc_q <= tick_o ? sum - AW'(den_q) : sum;
      if (tick_o) div_clk_o <= ~div_clk_o;
    end
  end
endmodule

// File: rtl/frac_rate_gen_chk.sv
module frac_rate_gen_chk #(
  parameter int FW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2*FW-1:0] cfg_word,
  input logic [FW-1:0]   num_q,
  input logic [FW-1:0]   den_q,
  input logic [FW:0]     acc_q,
  input logic            tick_o,
  input logic            div_clk_o
);
  wire zero_field = (cfg_word[2*FW-1:FW] == '0) || (cfg_word[FW-1:0] == '0);
  wire load_req   = !zero_field && (cfg_word != {num_q, den_q});
  wire held_ok    = (den_q != '0) && (num_q <= den_q);

  // R4
  invalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held_ok |-> !tick_o);

  // R3
  zero_field_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_field |=> (num_q == $past(num_q)) && (den_q == $past(den_q)));

  // R5
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (acc_q == '0) && !div_clk_o);

  // R6
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_ok |-> (acc_q < {1'b0, den_q}));

  // R7
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (den_q != '0 && num_q == den_q) |-> tick_o);

  // R8
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !load_req) |=> div_clk_o != $past(div_clk_o));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !load_req) |=> $stable(div_clk_o));
endmodule

bind frac_rate_gen frac_rate_gen_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .num_q(num_q),
  .den_q(den_q), .acc_q(acc_q), .tick_o(tick_o), .div_clk_o(div_clk_o)
);

// File: tb/tb_frac_rate_gen.sv
module tb_frac_rate_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic tick_o, div_clk_o;

  int checks = 0, fails = 0, cycles = 0;
  int mn = 0, mm = 0, macc = 0, mdiv = 0;
  bit done = 0;

  frac_rate_gen dut (.clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
                     .tick_o(tick_o), .div_clk_o(div_clk_o));

  always #5 clk = ~clk;

  function automatic bit m_ok();
    return (mm != 0) && (mn <= mm);
  endfunction

  function automatic bit m_tick();
    return m_ok() && (macc + mn >= mm);
  endfunction

  // reference model: state advances at each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      int wn, wm;
      bit t;
      wn = int'(cfg_word[31:16]);
      wm = int'(cfg_word[15:0]);
      t = m_tick();
      if (wn != 0 && wm != 0 && (wn != mn || wm != mm)) begin
        mn = wn; mm = wm; macc = 0; mdiv = 0;
      end else if (m_ok()) begin
        macc = macc + mn - (t ? mm : 0);
        if (t) mdiv = mdiv ^ 1;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison (R5, R8 phase and toggle)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tick_o == m_tick(), "R5 tick vs model", int'(tick_o), int'(m_tick()));
      chk(div_clk_o == mdiv[0], "R8 div_clk vs model", int'(div_clk_o), mdiv);
    end
  end

  task automatic run_ratio(int n, int m, int k);
    @(negedge clk);
    cfg_word = {n[15:0], m[15:0]};
    @(negedge clk);
    for (int w = 0; w < k; w++) begin
      int cnt = 0;
      for (int j = 0; j < m; j++) begin
        if (tick_o) cnt++;
        @(negedge clk);
      end
      chk(cnt == n, (n == m) ? "R7 full-rate window" : "R6 window count", cnt, n);
    end
  endtask

  task automatic count_ticks(int len, int exp, string req);
    int cnt = 0;
    for (int j = 0; j < len; j++) begin
      if (tick_o) cnt++;
      @(negedge clk);
    end
    chk(cnt == exp, req, cnt, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle from reset with no configuration
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tick_o == 0 && div_clk_o == 0, "R1 reset idle", int'(tick_o), 0);
    end
    // R2: field order, n=3 m=7
    run_ratio(3, 7, 6);
    // R3: zero denominator / numerator ignored, ratio keeps running
    cfg_word = {16'd5, 16'd0};
    count_ticks(7, 3, "R3 zero m ignored");
    cfg_word = {16'd0, 16'd9};
    count_ticks(14, 6, "R3 zero n ignored");
    // R9: repeating the held word keeps phase (model comparison each cycle)
    cfg_word = {16'd3, 16'd7};
    count_ticks(21, 9, "R9 same word no restart");
    run_ratio(5, 16, 5);
    run_ratio(1, 300, 3);
    run_ratio(1, 1, 8);
    run_ratio(255, 256, 4);
    run_ratio(1000, 1024, 3);
    // R5: first pulse after taking 2/9 comes ceil(9/2)=5 cycles on
    @(negedge clk);
    cfg_word = {16'd2, 16'd9};
    @(negedge clk);
    for (int j = 0; j < 5; j++) begin
      chk(tick_o == (j == 4), "R5 first pulse position", int'(tick_o), int'(j == 4));
      @(negedge clk);
    end
    // R4: n > m held but idle, div_clk frozen
    cfg_word = {16'd5, 16'd3};
    @(negedge clk);
    count_ticks(50, 0, "R4 invalid ratio idle");
    chk(div_clk_o == 0, "R4 div_clk held", int'(div_clk_o), 0);
    run_ratio(65535, 65535, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule